// File: doc/BRIEF.md
# Sync activity and polarity monitor

The block watches three single-bit sync levels that are already synchronous to the system clock: a horizontal sync, a vertical sync, and a sliced sync-on-green signal. For each of the three it keeps an activity flag. The flag is raised on any edge and dropped after a programmable number of edge-free clock cycles. It also measures the polarity of the horizontal sync and of the selected vertical sync. To do this it counts high and low cycles over a fixed measurement window, and it updates each polarity flag only when a window closes.

The horizontal polarity is used to invert the horizontal sync where needed. The block then registers the result, so that a downstream clock reference always receives pulses that are active high. Vertical polarity is judged on the vertical sync that an upstream selector passes on, not on the raw vertical pin. All flags are packed into a single status byte.

Top module: `sync_status_monitor`

## Requirements
- R1: An edge on hsync_in, vsync_in or sog_in sets that input's activity flag to 1 in the status byte one clock after the edge is sampled.
- R2: An activity flag falls to 0 once timeout_cfg consecutive sampled cycles have passed without an edge on its input. The next edge sets it to 1 again.
- R3: At the close of a window, a polarity flag becomes 1 (positive) if its signal was high for fewer cycles than it was low. Otherwise, including an exact tie, it becomes 0 (negative).
- R4: Polarity flags change only at window boundaries. The windows are WIN_LEN cycles long and are counted from the first clock after reset.
- R5: Vertical polarity is measured on vsync_sel_in. vsync_in only drives the vertical activity flag.
- R6: The status byte carries horizontal activity in bit 7, horizontal polarity in bit 5, vertical activity in bit 4, vertical polarity in bit 2 and sync-on-green activity in bit 1. Bits 6, 3 and 0 read 0.
- R7: Once the first window has closed, href_out equals hsync_in XOR NOT(horizontal polarity), delayed by one clock. Its pulses are therefore active high for either input polarity.
- R8: After a synchronous active-low reset, every status bit is 0. href_out stays 0 until the first window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync level |
| vsync_in | input | 1 | Raw vertical sync level (activity only) |
| vsync_sel_in | input | 1 | Selected vertical sync used for polarity |
| sog_in | input | 1 | Sliced sync-on-green level |
| timeout_cfg | input | TO_W | Edge-free cycles before a flag drops |
| status_o | output | 8 | Packed status byte |
| href_out | output | 1 | Polarity-corrected horizontal sync |

## Verification
Short high pulses on a low horizontal sync, paired with a mostly-high selected vertical sync, show that the two polarities are measured independently. Swapping both patterns shows that the reference output is then inverted rather than passed through. A raw vertical pin that toggles with a duty opposite to the selected signal shows that polarity does not come from the raw pin. Holding all inputs still separates the timeout drop from the polarity hold, a single edge afterwards shows recovery, and a 50% duty pattern settles the tie toward negative.

// File: rtl/sync_mon_pkg.sv
// Package: shared bit positions and input indices for the sync monitor.
// Assumes an 8-bit status byte whose layout is fixed by its consumer.
package sync_mon_pkg;
    localparam int NUM_SRC    = 3;
    localparam int SRC_HS     = 0;
    localparam int SRC_VS     = 1;
    localparam int SRC_SOG    = 2;

    localparam int BIT_HS_ACT  = 7;
    localparam int BIT_HS_POL  = 5;
    localparam int BIT_VS_ACT  = 4;
    localparam int BIT_VS_POL  = 2;
    localparam int BIT_SOG_ACT = 1;
endpackage

// File: rtl/sync_activity_det.sv
// Activity detector: raises a flag on any edge of a synchronous level and
// clears it after timeout_cfg consecutive edge-free cycles.
// Assumes sig_in is already synchronous to clk.
module sync_activity_det #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sig_in,
    input  logic [TO_W-1:0] timeout_cfg,
    output logic            active_o
);
    logic            prev_q;
    logic [TO_W-1:0] idle_q;
    logic [TO_W-1:0] idle_n;
    logic            edge_seen;

    // Edge flag and saturating idle count for this cycle.
    always_comb begin
        edge_seen = (sig_in != prev_q);
        if (edge_seen)
            idle_n = '0;
        else if (idle_q == {TO_W{1'b1}})
            idle_n = idle_q;
        else
            idle_n = idle_q + 1'b1;
    end

    // Register the previous sample, the idle count and the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            idle_q   <= '0;
            active_o <= 1'b0;
        end else begin
            prev_q <= sig_in;
            idle_q <= idle_n;
            if (edge_seen)
                active_o <= 1'b1;
            else if (idle_n >= timeout_cfg)
                active_o <= 1'b0;
        end
    end

    AST_ACT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_in != prev_q) |=> active_o); // R1

    AST_DROP_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> $stable(prev_q)); // R2
endmodule

// File: rtl/sync_polarity_det.sv
// Polarity detector: counts high cycles over a WIN_LEN window and, when the
// window closes, reports 1 if the signal was high fewer cycles than low.
// Assumes sig_in is synchronous; valid_o rises after the first window.
module sync_polarity_det #(
    parameter int WIN_LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic pol_o,
    output logic valid_o
);
    localparam int CW = $clog2(WIN_LEN + 1);

    logic [CW-1:0] win_q;
    logic [CW-1:0] high_q;
    logic [CW:0]   high_tot;
    logic          win_end;

    // High total including this cycle, and end-of-window flag.
    always_comb begin
        high_tot = {1'b0, high_q} + {{CW{1'b0}}, sig_in};
        win_end  = (win_q == CW'(WIN_LEN - 1));
    end

    // Window counting and polarity decision at the window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            high_q  <= '0;
            pol_o   <= 1'b0;
            valid_o <= 1'b0;
        end else if (win_end) begin
            win_q   <= '0;
            high_q  <= '0;
            pol_o   <= ((high_tot << 1) < (CW+1)'(WIN_LEN));
            valid_o <= 1'b1;
        end else begin
            win_q  <= win_q + 1'b1;
            high_q <= high_tot[CW-1:0];
        end
    end

    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q != '0) |-> $stable(pol_o)); // R4

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o); // R8
endmodule

// File: rtl/sync_status_monitor.sv
// Top: three activity detectors, two polarity detectors, the status byte and
// the polarity-corrected horizontal reference. Assumes synchronous inputs.
module sync_status_monitor
    import sync_mon_pkg::*;
#(
    parameter int TO_W    = 16,
    parameter int WIN_LEN = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hsync_in,
    input  logic            vsync_in,
    input  logic            vsync_sel_in,
    input  logic            sog_in,
    input  logic [TO_W-1:0] timeout_cfg,
    output logic [7:0]      status_o,
    output logic            href_out
);
    logic [NUM_SRC-1:0] src_vec;
    logic [NUM_SRC-1:0] act_vec;
    logic               hs_pol, hs_valid;
    logic               vs_pol, vs_valid;

    assign src_vec[SRC_HS]  = hsync_in;
    assign src_vec[SRC_VS]  = vsync_in;
    assign src_vec[SRC_SOG] = sog_in;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_act
        sync_activity_det #(.TO_W(TO_W)) i_act (
            .clk         (clk),
            .rst_n       (rst_n),
            .sig_in      (src_vec[g]),
            .timeout_cfg (timeout_cfg),
            .active_o    (act_vec[g])
        );
    end

    sync_polarity_det #(.WIN_LEN(WIN_LEN)) i_hpol (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (hsync_in),
        .pol_o   (hs_pol),
        .valid_o (hs_valid)
    );

    sync_polarity_det #(.WIN_LEN(WIN_LEN)) i_vpol (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (vsync_sel_in),
        .pol_o   (vs_pol),
        .valid_o (vs_valid)
    );

    // Pack flags into the status byte; spare bits read 0.
    always_comb begin
        status_o              = 8'h00;
        status_o[BIT_HS_ACT]  = act_vec[SRC_HS];
        status_o[BIT_HS_POL]  = hs_pol;
        status_o[BIT_VS_ACT]  = act_vec[SRC_VS];
        status_o[BIT_VS_POL]  = vs_pol & vs_valid;
        status_o[BIT_SOG_ACT] = act_vec[SRC_SOG];
    end

    // Corrected horizontal reference, held low until polarity is known.
    always_ff @(posedge clk) begin
        if (!rst_n)
            href_out <= 1'b0;
        else if (hs_valid)
            href_out <= hsync_in ^ ~hs_pol;
        else
            href_out <= 1'b0;
    end

    AST_HREF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hs_valid) |-> (href_out == ($past(hsync_in) ^ ~$past(hs_pol)))); // R7

    AST_HREF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_valid |-> !hs_pol); // R8
endmodule

// File: tb/test_sync_status_monitor.sv
module test_sync_status_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int TO_W       = 16;
    localparam int WIN_LEN    = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hsync_in = 1'b0, vsync_in = 1'b0, vsync_sel_in = 1'b0, sog_in = 1'b0;
    logic [TO_W-1:0] timeout_cfg = 16'd100;
    logic [7:0]      status_o;
    logic            href_out;

    int checks = 0;
    int fails  = 0;

    sync_status_monitor #(.TO_W(TO_W), .WIN_LEN(WIN_LEN)) i_sync_status_monitor (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .vsync_sel_in(vsync_sel_in), .sog_in(sog_in), .timeout_cfg(timeout_cfg),
        .status_o(status_o), .href_out(href_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int  idle [3];
    bit  act  [3];
    bit  prv  [3];
    int  wc, hi_h, hi_v;
    bit  polh, polv, valid, href_e, started;

    always @(posedge clk) begin
        bit cur [3];
        cur[0] = hsync_in; cur[1] = vsync_in; cur[2] = sog_in;
        started = 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin idle[i] = 0; act[i] = 0; prv[i] = 0; end
            wc = 0; hi_h = 0; hi_v = 0; polh = 0; polv = 0; valid = 0; href_e = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (cur[i] != prv[i]) begin idle[i] = 0; act[i] = 1; end
                else begin
                    if (idle[i] < 65535) idle[i]++;
                    if (idle[i] >= int'(timeout_cfg)) act[i] = 0;
                end
                prv[i] = cur[i];
            end
            href_e = valid ? (hsync_in ^ ~polh) : 1'b0;
            hi_h += int'(hsync_in); hi_v += int'(vsync_sel_in); wc++;
            if (wc == WIN_LEN) begin
                polh = (2*hi_h < WIN_LEN); polv = (2*hi_v < WIN_LEN);
                valid = 1; wc = 0; hi_h = 0; hi_v = 0;
            end
        end
    end

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, actual, expected, $time);
        end
    endtask

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            check("R1 hs activity",  status_o[7], act[0]);
            check("R1 vs activity",  status_o[4], act[1]);
            check("R2 sog activity", status_o[1], act[2]);
            check("R3 hs polarity",  status_o[5], polh);
            check("R5 vs polarity",  status_o[2], polv);
            check("R6 spare bits",   {status_o[6], status_o[3], status_o[0]}, 0);
            check("R7 href",         href_out, href_e);
        end
    end

    function automatic logic pulse(int k, int p, int w, bit inv);
        if (p == 0) return inv;
        return ((k % p) < w) ^ inv;
    endfunction

    task automatic drive(int n, int hp, int hw, bit hi, int vp, int vw, bit vi,
                         int rp, int sp);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            hsync_in     = pulse(k, hp, hw, hi);
            vsync_sel_in = pulse(k, vp, vw, vi);
            vsync_in     = pulse(k, rp, rp/2, 1'b0);
            sog_in       = pulse(k, sp, sp/2, 1'b0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R8 reset status", status_o, 8'h00);
        check("R8 reset href", href_out, 0);
        rst_n = 1'b1;
        // Before the first window: href held low (R8)
        drive(100, 40, 4, 0, 50, 5, 1, 30, 12);
        #1 check("R8 href low before window", href_out, 0);
        // Phase A: positive hsync, mostly-high selected vsync, raw vsync 50/50 (R5)
        drive(1100, 40, 4, 0, 50, 5, 1, 30, 12);
        #1 check("R6 phase A status", status_o, 8'hB2);
        // Phase B: negative hsync, mostly-low selected vsync
        drive(1100, 40, 4, 1, 50, 5, 0, 30, 12);
        #1 check("R7 phase B status", status_o, 8'h96);
        // Phase C: all idle low -> activity drops, polarity goes positive (R2)
        drive(700, 0, 0, 0, 0, 0, 0, 0, 0);
        #1 check("R2 idle status", status_o, 8'h24);
        // Phase D: one edge on every input (R1)
        @(negedge clk);
        hsync_in = 1; vsync_in = 1; sog_in = 1;
        @(negedge clk);
        check("R1 recovered flags", {status_o[7], status_o[4], status_o[1]}, 3'b111);
        // Phase E: exact 50% duty -> tie reads negative (R3, R4)
        timeout_cfg = 16'd20;
        drive(1100, 8, 4, 0, 8, 4, 0, 8, 8);
        #1 check("R3 tie status", status_o, 8'h92);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule